// File: doc/BRIEF.md
# Configurable LUT Logic Slice

This block is a behavioural, synthesizable model of one programmable logic slice from a LUT-based fabric. Four 64-entry truth tables are loaded over a one-bit serial configuration port. Each table works either as a single 6-input function or as two 5-input functions that share their inputs. Two wide multiplexers, steered by live user inputs, merge pairs of tables into 7-input functions. A third multiplexer merges those two results into an 8-input function.

Four storage bits follow the logic. Configuration makes each one an edge-triggered flip-flop or a level-sensitive latch, and it also fixes where each one takes its data. Until the configuration stream is complete, every output of the slice reads zero and no storage bit changes.

A user first holds `rst`, then shifts in exactly 272 configuration bits and waits for `cfgDone`. After that the slice is driven as plain logic. Loading a new configuration requires another reset.

Top module: `lut_slice`

## Requirements
- R1: The configuration word is 272 bits long and is shifted in MSB-first, one bit per clock in which `cfgEn` is high. The first 256 bits are the tables in the order A, B, C, D, each table's entry 63 arriving first. Next come four mode bits in the order A to D (1 selects dual output). Then come four storage-type bits in the order A to D (1 selects a latch). Last come four 2-bit source selects in the order A to D, each sent high bit first. `cfgDone` goes high on the clock edge that accepts bit 272, is never high before that edge, and stays high until reset.
- R2: A clock in which `cfgEn` is low does not consume the bit on `cfgData`. Bits offered after `cfgDone` is high leave the loaded configuration unchanged.
- R3: While `cfgDone` is low, `lutO6`, `lutO5`, `mux7Out`, `mux8Out` and `q` all read zero, and no storage bit changes.
- R4: For a table in single mode, the table's bit of `lutO6` is the entry indexed by that table's 6 inputs. Table t uses `lutIn[6t+5:6t]`, with A as t=0. The table's bit of `lutO5` is 0.
- R5: For a table in dual mode, the table's input 5 is ignored. The `lutO6` bit is the entry at index {1, input[4:0]}, and the `lutO5` bit is the entry at index {0, input[4:0]}.
- R6: `mux7Out[0]` is the `lutO6` bit of B when `sel7[0]` is 1 and the bit of A otherwise. `mux7Out[1]` is the bit of D when `sel7[1]` is 1 and the bit of C otherwise.
- R7: `mux8Out` is `mux7Out[1]` when `sel8` is 1 and `mux7Out[0]` otherwise.
- R8: Storage bit e takes its data from the source its 2-bit select names. Code 0 is the `lutO6` bit of table e and code 1 is the `lutO5` bit of table e. Code 2 is a wide multiplexer: `mux7Out[e/2]` for even e and `mux8Out` for odd e. Code 3 is `bypass[e]`.
- R9: In flip-flop mode, a rising clock edge with `srst` high clears the bit. With `srst` low and `ce` high the edge loads the data, and with both low the bit holds.
- R10: In latch mode, the bit follows its data while `clk` is high and `ce` is high, and it is cleared while `clk` is high and `srst` is high. While `clk` is low it holds.
- R11: A single table in single mode can implement a complete 4-to-1 multiplexer: data on inputs 0 to 3 and select on inputs 4 and 5.
- R12: A clock edge with `rst` high clears `cfgDone`, the bit count, the loaded configuration and all storage bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock; also the latch gate |
| rst | input | 1 | Synchronous reset of configuration and storage |
| cfgEn | input | 1 | Shift enable for the configuration stream |
| cfgData | input | 1 | Serial configuration bit |
| cfgDone | output | 1 | Configuration complete |
| lutIn | input | 24 | Six inputs for each of tables A to D |
| sel7 | input | 2 | Live selects of the two 7-input multiplexers |
| sel8 | input | 1 | Live select of the 8-input multiplexer |
| ce | input | 1 | Shared storage clock enable / latch gate |
| srst | input | 1 | Shared synchronous clear of the storage bits |
| bypass | input | 4 | Direct data inputs of the storage bits |
| lutO6 | output | 4 | Main output of each table |
| lutO5 | output | 4 | Second output of each table in dual mode |
| mux7Out | output | 2 | 7-input multiplexer outputs |
| mux8Out | output | 1 | 8-input multiplexer output |
| q | output | 4 | Storage bit outputs |

## Verification
The bench loads the configuration with idle gaps and then keeps shifting after done. A counter that did not skip idle cycles, or that did not freeze at completion, would raise `cfgDone` at the wrong bit or corrupt the tables, and the later comparisons of function would mismatch. The check on bit order leans on the 4-to-1 multiplexer table: reading the stream LSB-first, or packing the tables the wrong way round, changes that function at nearly every index. Dual mode is driven with input 5 toggling, so a table that did not force the upper address bit would show up on `lutO6`. A latch is moved while `clk` is high and again while it is low, and a flip-flop at the same moments, so swapping the two storage types, or opening the latch at the wrong clock level, would be reported. A mid-test reset checks that outputs fall back to zero and that a second, inverted configuration takes effect.

// File: rtl/slice_pkg.sv
package slice_pkg;
  // number of tables is fixed by the pairing of the wide multiplexers
  localparam int unsigned NUM_TAB = 4;
  localparam int unsigned SRC_W   = 2;
  localparam int unsigned WIDE_N  = NUM_TAB / 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_O6   = 2'd0,
    SRC_O5   = 2'd1,
    SRC_WIDE = 2'd2,
    SRC_BYP  = 2'd3
  } srcSel_e;

  // strobes from the configuration control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic done;
  } cfgStrobe_t;
endpackage

// File: rtl/slice_cfg_ctrl.sv
module slice_cfg_ctrl
  import slice_pkg::*;
#(
  parameter int unsigned CFG_BITS = 272
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgEn,
  output cfgStrobe_t strobe
);
  localparam int unsigned CW = $clog2(CFG_BITS + 1);

  logic [CW-1:0] bitCnt;
  logic          doneQ;
  logic          accept;

  assign accept = cfgEn & ~doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else if (accept) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == CW'(CFG_BITS - 1)) doneQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.shiftEn = accept;
    strobe.done    = doneQ;
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> doneQ); // R1
  AST_DONE_EXACT: assert property (@(posedge clk) disable iff (rst)
    $rose(doneQ) |-> ($past(bitCnt) == CW'(CFG_BITS - 1))); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= CW'(CFG_BITS)); // R2
endmodule

// File: rtl/slice_lut.sv
module slice_lut #(
  parameter int unsigned K = 6
) (
  input  logic [(1<<K)-1:0] tbl,
  input  logic [K-1:0]      idx,
  input  logic              dual,
  output logic              o6,
  output logic              o5
);
  logic [K-2:0] lowIdx;
  assign lowIdx = idx[K-2:0];

  always_comb begin
    if (dual) begin
      // top input forced high for the main output, low for the second
      o6 = tbl[{1'b1, lowIdx}];
      o5 = tbl[{1'b0, lowIdx}];
    end else begin
      o6 = tbl[idx];
      o5 = 1'b0;
    end
  end
endmodule

// File: rtl/slice_store.sv
module slice_store (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic isLatch,
  input  logic d,
  input  logic ce,
  input  logic srst,
  output logic q
);
  logic ffQ;
  logic latQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ffQ <= 1'b0;
    end else if (enable && !isLatch) begin
      if (srst)    ffQ <= 1'b0;
      else if (ce) ffQ <= d;
    end
  end

  // transparent while the clock is high and the gate is open
  always_latch begin
    if (rst) begin
      latQ <= 1'b0;
    end else if (enable && isLatch && clk && (ce || srst)) begin
      latQ <= srst ? 1'b0 : d;
    end
  end

  assign q = isLatch ? latQ : ffQ;

  AST_FF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && !isLatch && !ce && !srst) |=> $stable(ffQ)); // R9
  AST_FF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (enable && !isLatch && srst) |=> (ffQ == 1'b0)); // R9
  AST_FF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(ffQ)); // R3
endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
#(
  parameter int unsigned LUT_K = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  cfgStrobe_t                 strobe,
  input  logic                       cfgData,
  input  logic [NUM_TAB*LUT_K-1:0]   lutIn,
  input  logic [WIDE_N-1:0]          sel7,
  input  logic                       sel8,
  input  logic                       ce,
  input  logic                       srst,
  input  logic [NUM_TAB-1:0]         bypass,
  output logic [NUM_TAB-1:0]         lutO6,
  output logic [NUM_TAB-1:0]         lutO5,
  output logic [WIDE_N-1:0]          mux7Out,
  output logic                       mux8Out,
  output logic [NUM_TAB-1:0]         q
);
  localparam int unsigned TW        = 1 << LUT_K;
  localparam int unsigned CFG_BITS  = NUM_TAB*TW + NUM_TAB*(2 + SRC_W);
  localparam int unsigned MODE_BASE = NUM_TAB*(1 + SRC_W);
  localparam int unsigned TYPE_BASE = NUM_TAB*SRC_W;

  logic [CFG_BITS-1:0] cfgVec;
  logic [NUM_TAB-1:0]  o6Raw;
  logic [NUM_TAB-1:0]  o5Raw;
  logic [NUM_TAB-1:0]  qRaw;
  logic [WIDE_N-1:0]   mux7Raw;
  logic                mux8Raw;

  always_ff @(posedge clk) begin
    if (rst)                 cfgVec <= '0;
    else if (strobe.shiftEn) cfgVec <= {cfgVec[CFG_BITS-2:0], cfgData};
  end

  for (genvar t = 0; t < NUM_TAB; t++) begin : g_tab
    logic [TW-1:0] tbl;
    assign tbl = cfgVec[CFG_BITS-1-t*TW -: TW];
    slice_lut #(.K(LUT_K)) u_lut (
      .tbl  (tbl),
      .idx  (lutIn[t*LUT_K +: LUT_K]),
      .dual (cfgVec[MODE_BASE + NUM_TAB-1-t]),
      .o6   (o6Raw[t]),
      .o5   (o5Raw[t])
    );
  end

  for (genvar w = 0; w < WIDE_N; w++) begin : g_wide
    assign mux7Raw[w] = sel7[w] ? o6Raw[2*w+1] : o6Raw[2*w];
  end
  assign mux8Raw = sel8 ? mux7Raw[1] : mux7Raw[0];

  for (genvar e = 0; e < NUM_TAB; e++) begin : g_store
    logic    wideSig;
    logic    dSel;
    srcSel_e srcSel;
    if (e % 2 == 0) begin : g_even
      assign wideSig = mux7Raw[e/2];
    end else begin : g_odd
      assign wideSig = mux8Raw;
    end
    assign srcSel = srcSel_e'(cfgVec[SRC_W*(NUM_TAB-1-e) +: SRC_W]);
    always_comb begin
      case (srcSel)
        SRC_O6:   dSel = o6Raw[e];
        SRC_O5:   dSel = o5Raw[e];
        SRC_WIDE: dSel = wideSig;
        default:  dSel = bypass[e];
      endcase
    end
    slice_store u_store (
      .clk     (clk),
      .rst     (rst),
      .enable  (strobe.done),
      .isLatch (cfgVec[TYPE_BASE + NUM_TAB-1-e]),
      .d       (dSel),
      .ce      (ce),
      .srst    (srst),
      .q       (qRaw[e])
    );
  end

  always_comb begin
    lutO6   = strobe.done ? o6Raw   : '0;
    lutO5   = strobe.done ? o5Raw   : '0;
    mux7Out = strobe.done ? mux7Raw : '0;
    mux8Out = strobe.done & mux8Raw;
    q       = strobe.done ? qRaw    : '0;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    strobe.done |=> $stable(cfgVec)); // R2
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> $stable(cfgVec)); // R2
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import slice_pkg::*;
#(
  parameter int unsigned LUT_K = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfgEn,
  input  logic                     cfgData,
  output logic                     cfgDone,
  input  logic [NUM_TAB*LUT_K-1:0] lutIn,
  input  logic [WIDE_N-1:0]        sel7,
  input  logic                     sel8,
  input  logic                     ce,
  input  logic                     srst,
  input  logic [NUM_TAB-1:0]       bypass,
  output logic [NUM_TAB-1:0]       lutO6,
  output logic [NUM_TAB-1:0]       lutO5,
  output logic [WIDE_N-1:0]        mux7Out,
  output logic                     mux8Out,
  output logic [NUM_TAB-1:0]       q
);
  localparam int unsigned CFG_BITS = NUM_TAB*(1 << LUT_K) + NUM_TAB*(2 + SRC_W);

  cfgStrobe_t strobe;

  slice_cfg_ctrl #(.CFG_BITS(CFG_BITS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cfgEn  (cfgEn),
    .strobe (strobe)
  );

  slice_datapath #(.LUT_K(LUT_K)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .cfgData (cfgData),
    .lutIn   (lutIn),
    .sel7    (sel7),
    .sel8    (sel8),
    .ce      (ce),
    .srst    (srst),
    .bypass  (bypass),
    .lutO6   (lutO6),
    .lutO5   (lutO5),
    .mux7Out (mux7Out),
    .mux8Out (mux8Out),
    .q       (q)
  );

  assign cfgDone = strobe.done;

  AST_Q_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cfgDone |-> (q == '0 && mux8Out == 1'b0)); // R3
endmodule

// File: tb/sim_lut_slice.sv
`timescale 1ns/1ps
module sim_lut_slice;
  localparam int NT = 4;
  localparam int TW = 64;
  localparam int CFG_BITS = NT*TW + NT*4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, cfgEn = 1'b0, cfgData = 1'b0, sel8 = 1'b0, ce = 1'b0, srst = 1'b0;
  logic [23:0] lutIn = '0;
  logic [1:0] sel7 = '0;
  logic [3:0] bypass = '0;
  logic cfgDone, mux8Out;
  logic [3:0] lutO6, lutO5, q;
  logic [1:0] mux7Out;

  lut_slice u0 (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgData(cfgData), .cfgDone(cfgDone),
    .lutIn(lutIn), .sel7(sel7), .sel8(sel8), .ce(ce), .srst(srst), .bypass(bypass),
    .lutO6(lutO6), .lutO5(lutO5), .mux7Out(mux7Out), .mux8Out(mux8Out), .q(q)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference configuration
  logic [TW-1:0] mTbl [NT];
  logic [NT-1:0] mDual, mLatch;
  logic [1:0]    mSrc [NT];
  logic          mCfgd = 1'b0;
  logic [3:0]    expQ = '0;

  function automatic logic [CFG_BITS-1:0] packCfg();
    logic [CFG_BITS-1:0] v = '0;
    for (int t = 0; t < NT; t++) begin
      v[CFG_BITS-1-t*TW -: TW] = mTbl[t];
      v[4*NT-1-t] = mDual[t];
      v[3*NT-1-t] = mLatch[t];
      v[2*(NT-1-t) +: 2] = mSrc[t];
    end
    return v;
  endfunction

  // {mux8, mux7[1:0], o5[3:0], o6[3:0]}
  function automatic logic [10:0] modelComb(logic [23:0] in_, logic [1:0] s7, logic s8);
    logic [3:0] o6, o5;
    logic [1:0] m7;
    logic [5:0] ix;
    for (int t = 0; t < NT; t++) begin
      ix = in_[t*6 +: 6];
      if (mDual[t]) begin
        o6[t] = mTbl[t][{1'b1, ix[4:0]}];
        o5[t] = mTbl[t][{1'b0, ix[4:0]}];
      end else begin
        o6[t] = mTbl[t][ix];
        o5[t] = 1'b0;
      end
    end
    m7[0] = s7[0] ? o6[1] : o6[0];
    m7[1] = s7[1] ? o6[3] : o6[2];
    return {(s8 ? m7[1] : m7[0]), m7, o5, o6};
  endfunction

  typedef struct { string req; logic [10:0] comb; logic [3:0] qv; } item_t;
  item_t sb[$];

  // driver: inputs change while clk is low, expectation queued for the next high phase
  task automatic step(string req, logic [23:0] in_, logic [1:0] s7, logic s8,
                      logic ce_, logic srst_, logic [3:0] byp);
    item_t it;
    logic [10:0] c;
    logic [3:0] dv;
    @(negedge clk); #1;
    lutIn = in_; sel7 = s7; sel8 = s8; ce = ce_; srst = srst_; bypass = byp;
    c = modelComb(in_, s7, s8);
    for (int e = 0; e < NT; e++) begin
      case (mSrc[e])
        2'd0: dv[e] = c[e];
        2'd1: dv[e] = c[4+e];
        2'd2: dv[e] = (e % 2 == 0) ? c[8 + e/2] : c[10];
        default: dv[e] = byp[e];
      endcase
    end
    if (mCfgd) begin
      if (srst_) expQ = '0;
      else if (ce_) expQ = dv;
    end
    it.req  = req;
    it.comb = mCfgd ? c : 11'd0;
    it.qv   = mCfgd ? expQ : 4'd0;
    sb.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    item_t it;
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      check({it.req, " comb"}, {21'd0, mux8Out, mux7Out, lutO5, lutO6}, {21'd0, it.comb});
      check({it.req, " q"}, {28'd0, q}, {28'd0, it.qv});
    end
  end

  task automatic drain();
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk); #2;
  endtask

  task automatic shiftCfg(logic [CFG_BITS-1:0] v);
    for (int i = CFG_BITS-1; i >= 0; i--) begin
      if (i % 37 == 0) begin
        @(negedge clk); #1;
        cfgEn = 1'b0; cfgData = ~v[i];
      end
      @(negedge clk); #1;
      if (i == 0) check("R1 done before last bit", {31'd0, cfgDone}, 32'd0);
      cfgEn = 1'b1; cfgData = v[i];
    end
    @(negedge clk); #1;
    cfgEn = 1'b0;
    check("R1 done after last bit", {31'd0, cfgDone}, 32'd1);
    // R2: extra bits after completion must be dropped
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      cfgEn = 1'b1; cfgData = i[0] ^ i[2];
    end
    @(negedge clk); #1;
    cfgEn = 1'b0;
    check("R1 done sticky", {31'd0, cfgDone}, 32'd1);
  endtask

  task automatic runPatterns(string req, int n, int seed);
    for (int i = 0; i < n; i++) begin
      int k;
      k = i + seed;
      step(req, {6'(k*5+3), 6'(k*11+1), 6'(k*13+32), 6'(k*7)},
           2'(k ^ (k >> 2)), k[4], (k % 5 != 0), (k % 9 == 4), 4'(k ^ 4'hA));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset cfgDone", {31'd0, cfgDone}, 32'd0);
    check("R12 reset q", {28'd0, q}, 32'd0);
    @(negedge clk); #1;
    rst = 1'b0;

    // R3: nothing moves before configuration
    step("R3 pre-config", 24'hFFFFFF, 2'b11, 1'b1, 1'b1, 1'b0, 4'hF);
    step("R3 pre-config", 24'h5A5A5A, 2'b01, 1'b0, 1'b1, 1'b0, 4'hF);
    drain();

    // configuration 1: A is a 4-to-1 multiplexer (R11)
    for (int k = 0; k < TW; k++) mTbl[0][k] = k[k >> 4];
    mTbl[1] = 64'hDEADBEEF0123ABCD;
    mTbl[2] = 64'hF0F03C3CA5A50FF0;
    mTbl[3] = 64'h6996966996696996;
    mDual  = 4'b1010;
    mLatch = 4'b1100;
    mSrc[0] = 2'd0; mSrc[1] = 2'd1; mSrc[2] = 2'd2; mSrc[3] = 2'd3;
    shiftCfg(packCfg());
    mCfgd = 1'b1;

    // R11 R4: every index of the multiplexer table
    for (int i = 0; i < 64; i++)
      step("R11 R4 mux4 table", {6'(i*3), 6'(i*5+1), 6'(i ^ 6'h2A), 6'(i)},
           2'(i), i[2], 1'b1, 1'b0, 4'(i));
    // R5 R6 R7 R8 R9: mixed patterns with enables and clears
    runPatterns("R4 R5 R6 R7 R8 R9", 48, 0);
    drain();

    // R10 latch versus flip-flop timing
    step("R10 setup", 24'h000000, 2'b00, 1'b0, 1'b1, 1'b0, 4'h0);
    drain();
    @(posedge clk); #1.5;
    bypass = 4'b1000;
    #0.2;
    check("R10 latch follows while clk high", {31'd0, q[3]}, 32'd1);
    check("R9 flip-flop holds between edges", {31'd0, q[1]}, {31'd0, expQ[1]});
    @(negedge clk); #0.5;
    ce = 1'b0;
    bypass = 4'b0000;
    #0.2;
    check("R10 latch holds while clk low", {31'd0, q[3]}, 32'd1);
    expQ[3] = 1'b1;
    step("R10 gate closed", 24'h000000, 2'b00, 1'b0, 1'b0, 1'b0, 4'h0);
    step("R10 clear", 24'h000000, 2'b00, 1'b0, 1'b0, 1'b1, 4'hF);
    drain();

    // R12: reset drops configuration
    @(negedge clk); #1;
    rst = 1'b1; lutIn = 24'hFFFFFF; bypass = 4'hF; ce = 1'b1;
    @(posedge clk); #1;
    check("R12 cfgDone cleared", {31'd0, cfgDone}, 32'd0);
    check("R12 outputs cleared", {21'd0, mux8Out, mux7Out, lutO5, lutO6}, 32'd0);
    check("R12 q cleared", {28'd0, q}, 32'd0);
    @(negedge clk); #1;
    rst = 1'b0;
    mCfgd = 1'b0;
    expQ = '0;

    // configuration 2: modes, types and sources inverted
    mDual  = 4'b0101;
    mLatch = 4'b0011;
    mSrc[0] = 2'd3; mSrc[1] = 2'd2; mSrc[2] = 2'd1; mSrc[3] = 2'd0;
    shiftCfg(packCfg());
    mCfgd = 1'b1;
    runPatterns("R5 R8 R9 R10", 40, 17);
    drain();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule